// File: doc/BRIEF.md
# JTAG Debug Control Data Register

This block is a 32-bit debug control data register that sits behind a JTAG test access port. It bridges the test clock (TCK) domain and a processor clock domain. A debugger scans it like any other data register. At Capture-DR it loads a snapshot of processor status and the current control settings. During Shift-DR that snapshot leaves on TDO, least significant bit first, while the new value enters on TDI. At Update-DR the new value is committed, but only if a gating rule allows it.

The processor side reports reset, debug mode, halt, low-power (doze) state, and the size, direction and presence of a pending memory access. Each of these status levels passes through a synchroniser before it is captured. The debugger drives five control outputs back toward the processor, and each passes through a synchroniser in the processor clock domain: probe enable, probe trap-vector select, debug break request, processor reset request and peripheral reset request. A sticky reset-occurred flag records every processor reset. The flag blocks all updates until the debugger acknowledges it by writing it to 0. The TAP state machine and instruction decode are outside this block.

Top module: `dbg_ctl_dr`

## Requirements
- R1: The captured word has this layout: bit 31 is reset-occurred, bits 30:29 are the access size, bit 22 is doze, bit 21 is halt, bit 20 is the peripheral reset request, bit 19 is the access direction (1 = write), bit 18 is access pending, bit 16 is the processor reset request, bit 15 is probe enable, bit 14 is trap select, bit 12 is break request and bit 3 is debug mode. Every other bit reads 0.
- R2: Capture-DR loads the word into the shift register. Each TCK rising edge with Shift-DR shifts it one place toward bit 0, with TDI entering at bit 31. TDO shows bit 0 and changes on the TCK falling edge.
- R3: An Update-DR is applied only if reset-occurred is already 0 or the shifted-in bit 31 is 0. Otherwise the whole update is ignored.
- R4: Reset-occurred is forced to 1 while the synchronised processor reset is high. It appears in the TCK domain no earlier than the third TCK rising edge after the reset level rises. It stays 1 after the reset is released until an accepted update writes 0 to it. Writing 1 to it has no effect.
- R5: An accepted update stores bits 20, 16, 15, 14 and 12. The stored values are returned at the very next Capture-DR, including a capture on the TCK edge right after the update.
- R6: Writes to read-only and reserved bit positions are ignored.
- R7: A rising edge of the synchronised access-request input sets access pending. An accepted update with bit 18 at 0 clears it, and writing 1 to bit 18 leaves it unchanged. A set on the same edge wins over a clear. The flag is also driven to the processor domain.
- R8: The status inputs (debug mode, halt, doze, size, direction, request, reset) pass through two TCK flops before any capture can see them.
- R9: The five control bits and the access-pending flag reach the processor-side outputs through two processor-clock flops.
- R10: TAP reset clears all five control bits. The asynchronous TAP reset (trst_n low) also sets reset-occurred to 1 and clears access pending. The synchronous Test-Logic-Reset strobe leaves both of those flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous TAP reset, active low |
| tlr | input | 1 | Test-Logic-Reset state strobe (TCK domain) |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| cpu_clk | input | 1 | Processor clock |
| cpu_rst | input | 1 | Processor reset level, active high |
| cpu_debug_mode | input | 1 | Processor is in debug mode |
| cpu_halt | input | 1 | Processor is halted |
| cpu_doze | input | 1 | Processor is in low-power state |
| cpu_acc_req | input | 1 | Pending access request level |
| cpu_acc_size | input | 2 | Size of the pending access |
| cpu_acc_write | input | 1 | Pending access is a write |
| cpu_probe_en | output | 1 | Probe enable, processor domain |
| cpu_trap_sel | output | 1 | Probe trap-vector select, processor domain |
| cpu_brk_req | output | 1 | Debug break request, processor domain |
| cpu_rst_req | output | 1 | Processor reset request, processor domain |
| cpu_per_rst_req | output | 1 | Peripheral reset request, processor domain |
| cpu_acc_pend | output | 1 | Access pending flag, processor domain |

## Verification
The bench first tries to write control bits while reset-occurred is set. A design that gated the update on the old flag alone, or on the new bit alone, would let that write through or block the acknowledging write. Status is changed on the edge just before a capture, to catch a missing synchroniser stage. The gating is then re-tested with a processor reset held through a scan, and after it ends, to catch a flag that is not sticky. Every scan starts its capture on the edge right after the previous update, so a readback taken from the synchronised processor-side copy would return stale data. A pending flag that obeyed a written 1, or that re-armed on a held request level, would also show in the readback.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int DR_W     = 32;
  localparam int B_ROCC   = 31;
  localparam int B_SZ_LO  = 29;
  localparam int B_DOZE   = 22;
  localparam int B_HALT   = 21;
  localparam int B_PERRST = 20;
  localparam int B_DIR    = 19;
  localparam int B_PEND   = 18;
  localparam int B_PRRST  = 16;
  localparam int B_PROBE  = 15;
  localparam int B_TRAP   = 14;
  localparam int B_BRK    = 12;
  localparam int B_DM     = 3;

  typedef struct packed {
    logic per_rst;
    logic pr_rst;
    logic probe_en;
    logic trap_sel;
    logic brk;
  } ctl_t;

  typedef struct packed {
    logic [1:0] size;
    logic       doze;
    logic       halt;
    logic       wr;
    logic       dm;
    logic       req;
  } stat_t;

  localparam int CTL_W  = $bits(ctl_t);
  localparam int STAT_W = $bits(stat_t);

  function automatic logic [DR_W-1:0] pack_word(logic rocc, logic pend, stat_t s, ctl_t c);
    logic [DR_W-1:0] w;
    w                      = '0;
    w[B_ROCC]              = rocc;
    w[B_SZ_LO+1:B_SZ_LO]   = s.size;
    w[B_DOZE]              = s.doze;
    w[B_HALT]              = s.halt;
    w[B_PERRST]            = c.per_rst;
    w[B_DIR]               = s.wr;
    w[B_PEND]              = pend;
    w[B_PRRST]             = c.pr_rst;
    w[B_PROBE]             = c.probe_en;
    w[B_TRAP]              = c.trap_sel;
    w[B_BRK]               = c.brk;
    w[B_DM]                = s.dm;
    return w;
  endfunction

  function automatic ctl_t unpack_ctl(logic [DR_W-1:0] w);
    ctl_t c;
    c.per_rst  = w[B_PERRST];
    c.pr_rst   = w[B_PRRST];
    c.probe_en = w[B_PROBE];
    c.trap_sel = w[B_TRAP];
    c.brk      = w[B_BRK];
    return c;
  endfunction

  function automatic logic write_ok(logic rocc, logic [DR_W-1:0] w);
    return !rocc || !w[B_ROCC];
  endfunction
endpackage

// File: rtl/dbg_sync2.sv
module dbg_sync2 #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dbg_dr_shift.sv
module dbg_dr_shift #(
  parameter int W = 32
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         capture,
  input  logic         shift,
  input  logic         tdi,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] sh_q,
  output logic         tdo
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      sh_q <= '0;
    else if (capture) sh_q <= par_in;
    else if (shift)   sh_q <= {tdi, sh_q[W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else         tdo <= sh_q[0];
  end
endmodule

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
  import dbg_ctl_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tlr,
  input  logic            update,
  input  logic [DR_W-1:0] wr_word,
  input  logic            rst_seen,
  input  logic            req_seen,
  output logic            rocc,
  output logic            pend,
  output ctl_t            ctl,
  output logic            upd_ok,
  output logic            set_evt
);
  logic req_d;

  assign set_evt = req_seen && !req_d;
  assign upd_ok  = update && write_ok(rocc, wr_word);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rocc  <= 1'b1;
      pend  <= 1'b0;
      req_d <= 1'b0;
      ctl   <= '0;
    end else begin
      req_d <= req_seen;
      if (rst_seen)                       rocc <= 1'b1;
      else if (upd_ok && !wr_word[B_ROCC]) rocc <= 1'b0;
      if (set_evt)                        pend <= 1'b1;
      else if (upd_ok && !wr_word[B_PEND]) pend <= 1'b0;
      if (tlr)         ctl <= '0;
      else if (upd_ok) ctl <= unpack_ctl(wr_word);
    end
  end
endmodule

// File: rtl/dbg_ctl_dr.sv
module dbg_ctl_dr
  import dbg_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tlr,
  input  logic       capture_dr,
  input  logic       shift_dr,
  input  logic       update_dr,
  input  logic       tdi,
  output logic       tdo,
  input  logic       cpu_clk,
  input  logic       cpu_rst,
  input  logic       cpu_debug_mode,
  input  logic       cpu_halt,
  input  logic       cpu_doze,
  input  logic       cpu_acc_req,
  input  logic [1:0] cpu_acc_size,
  input  logic       cpu_acc_write,
  output logic       cpu_probe_en,
  output logic       cpu_trap_sel,
  output logic       cpu_brk_req,
  output logic       cpu_rst_req,
  output logic       cpu_per_rst_req,
  output logic       cpu_acc_pend
);
  localparam int IN_W  = STAT_W + 1;
  localparam int OUT_W = CTL_W + 1;

  stat_t           stat_raw, stat_s;
  logic            rst_seen;
  logic [DR_W-1:0] sh_q, cap_word;
  logic            rocc, pend, upd_ok, set_evt;
  ctl_t            ctl_q, ctl_cpu;
  logic            pend_cpu;

  assign stat_raw = '{size: cpu_acc_size, doze: cpu_doze, halt: cpu_halt,
                      wr: cpu_acc_write, dm: cpu_debug_mode, req: cpu_acc_req};

  dbg_sync2 #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync_in (
    .clk(tck), .rst_n(trst_n), .d({cpu_rst, stat_raw}), .q({rst_seen, stat_s})
  );

  assign cap_word = pack_word(rocc, pend, stat_s, ctl_q);

  dbg_dr_shift #(.W(DR_W)) u_shift (
    .tck(tck), .trst_n(trst_n), .capture(capture_dr), .shift(shift_dr),
    .tdi(tdi), .par_in(cap_word), .sh_q(sh_q), .tdo(tdo)
  );

  dbg_ctl_regs u_regs (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .update(update_dr), .wr_word(sh_q),
    .rst_seen(rst_seen), .req_seen(stat_s.req), .rocc(rocc), .pend(pend),
    .ctl(ctl_q), .upd_ok(upd_ok), .set_evt(set_evt)
  );

  dbg_sync2 #(.W(OUT_W), .STAGES(SYNC_STAGES)) u_sync_out (
    .clk(cpu_clk), .rst_n(trst_n), .d({ctl_q, pend}), .q({ctl_cpu, pend_cpu})
  );

  assign cpu_probe_en    = ctl_cpu.probe_en;
  assign cpu_trap_sel    = ctl_cpu.trap_sel;
  assign cpu_brk_req     = ctl_cpu.brk;
  assign cpu_rst_req     = ctl_cpu.pr_rst;
  assign cpu_per_rst_req = ctl_cpu.per_rst;
  assign cpu_acc_pend    = pend_cpu;
endmodule

// File: rtl/dbg_ctl_dr_chk.sv
module dbg_ctl_dr_chk
  import dbg_ctl_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tlr,
  input logic            capture_dr,
  input logic            shift_dr,
  input logic            update_dr,
  input logic            tdi,
  input logic [DR_W-1:0] sh_q,
  input logic            rocc,
  input logic            pend,
  input ctl_t            ctl_q,
  input logic            upd_ok,
  input logic            rst_seen,
  input logic            set_evt
);
  assert_shift_in_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr) |=> (sh_q[DR_W-1] == $past(tdi)));

  assert_blocked_update_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (update_dr && rocc && sh_q[B_ROCC] && !tlr) |=> $stable(ctl_q));

  assert_rocc_set_R4: assert property (@(posedge tck) disable iff (!trst_n)
    rst_seen |=> rocc);

  assert_rocc_sticky_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (rocc && !update_dr) |=> rocc);

  assert_rocc_source_R4: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(rocc) |-> $past(rst_seen));

  assert_pend_source_R7: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(pend) |-> $past(set_evt));

  assert_pend_hold_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (pend && !upd_ok) |=> pend);

  assert_tap_reset_R10: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> (ctl_q == '0));
endmodule

bind dbg_ctl_dr dbg_ctl_dr_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_dr(capture_dr),
  .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .sh_q(sh_q),
  .rocc(rocc), .pend(pend), .ctl_q(ctl_q), .upd_ok(upd_ok),
  .rst_seen(rst_seen), .set_evt(set_evt)
);

// File: tb/dbg_ctl_dr_bench.sv
module dbg_ctl_dr_bench;
  logic tck = 1'b0, cpu_clk = 1'b0;
  logic trst_n = 1'b0, tlr = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic cpu_rst = 1'b0, cpu_debug_mode = 1'b0, cpu_halt = 1'b0, cpu_doze = 1'b0;
  logic cpu_acc_req = 1'b0, cpu_acc_write = 1'b0;
  logic [1:0] cpu_acc_size = 2'b00;
  logic cpu_probe_en, cpu_trap_sel, cpu_brk_req, cpu_rst_req, cpu_per_rst_req, cpu_acc_pend;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #10 tck = ~tck;
  always #7  cpu_clk = ~cpu_clk;

  dbg_ctl_dr u_dbg_ctl_dr (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .cpu_debug_mode(cpu_debug_mode),
    .cpu_halt(cpu_halt), .cpu_doze(cpu_doze), .cpu_acc_req(cpu_acc_req),
    .cpu_acc_size(cpu_acc_size), .cpu_acc_write(cpu_acc_write),
    .cpu_probe_en(cpu_probe_en), .cpu_trap_sel(cpu_trap_sel),
    .cpu_brk_req(cpu_brk_req), .cpu_rst_req(cpu_rst_req),
    .cpu_per_rst_req(cpu_per_rst_req), .cpu_acc_pend(cpu_acc_pend)
  );

  // Control bits 20,16,15,14,12 all set
  localparam logic [31:0] CTL_ALL = 32'h0011_D000;
  localparam int NV = 6;
  localparam logic [31:0] TBL_DIN [NV] = '{32'h0001_0000, 32'hFFFF_FFFF, 32'h0000_0000,
                                           32'h0010_1000, 32'h8000_C000, 32'h6E68_2FFF};
  localparam logic [31:0] TBL_EXP [NV] = '{32'h0001_0000, 32'h0011_D000, 32'h0000_0000,
                                           32'h0010_1000, 32'h0000_C000, 32'h0000_0000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge tck);
  endtask

  // Entered at a falling edge; leaves at a falling edge right after the update edge.
  task automatic scan(input logic [31:0] din, output logic [31:0] dout);
    capture_dr = 1'b1;
    @(negedge tck);
    capture_dr = 1'b0;
    shift_dr   = 1'b1;
    for (int i = 0; i < 32; i++) begin
      #1;
      dout[i] = tdo;
      tdi     = din[i];
      @(negedge tck);
    end
    shift_dr  = 1'b0;
    update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
  endtask

  function automatic logic [31:0] cpu_ctl_bus();
    return {27'd0, cpu_per_rst_req, cpu_rst_req, cpu_probe_en, cpu_trap_sel, cpu_brk_req};
  endfunction

  initial begin
    repeat (100000) @(posedge tck);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #55 trst_n = 1'b1;
    @(negedge tck);
    idle(4);
    chk("R10 reset outputs", {cpu_ctl_bus()[31:1], cpu_acc_pend}, 32'h0);

    scan(32'h8001_D000, rd);
    chk("R1 R4 rocc after trst", rd, 32'h8000_0000);
    scan(CTL_ALL, rd);
    chk("R3 update blocked", rd, 32'h8000_0000);
    scan(32'h0, rd);
    chk("R5 write and rocc clear", rd, CTL_ALL);

    for (int i = 0; i < NV; i++) begin
      scan(TBL_DIN[i], rd);
      chk("R2 R5 R6 table", rd, (i == 0) ? 32'h0 : TBL_EXP[i-1]);
    end
    scan(CTL_ALL, rd);
    chk("R2 R5 R6 table last", rd, TBL_EXP[NV-1]);
    idle(5);
    chk("R9 cpu control outputs", cpu_ctl_bus(), 32'h1F);

    cpu_debug_mode = 1'b1; cpu_halt = 1'b1; cpu_doze = 1'b1;
    cpu_acc_size = 2'b10; cpu_acc_write = 1'b1;
    scan(CTL_ALL, rd);
    chk("R8 status not yet synced", rd, CTL_ALL);
    idle(3);
    scan(CTL_ALL, rd);
    chk("R1 R8 status bits", rd, 32'h4079_D008);
    cpu_debug_mode = 1'b0; cpu_halt = 1'b0; cpu_doze = 1'b0;
    cpu_acc_size = 2'b00; cpu_acc_write = 1'b0;
    idle(3);

    cpu_acc_req = 1'b1;
    idle(4);
    scan(32'h0015_D000, rd);
    chk("R7 pending set", rd, 32'h0015_D000);
    scan(CTL_ALL, rd);
    chk("R7 write 1 keeps pending", rd, 32'h0015_D000);
    scan(CTL_ALL, rd);
    chk("R7 write 0 clears pending", rd, CTL_ALL);
    idle(5);
    chk("R9 R7 cpu pending cleared", {31'd0, cpu_acc_pend}, 32'h0);
    cpu_acc_req = 1'b0;
    idle(3);

    cpu_rst = 1'b1;
    scan(CTL_ALL, rd);
    chk("R4 rocc delayed", rd, CTL_ALL);
    scan(32'h0, rd);
    chk("R4 rocc during reset", rd, 32'h8011_D000);
    cpu_rst = 1'b0;
    idle(4);
    scan(32'h8011_D000, rd);
    chk("R4 rocc sticky", rd, 32'h8000_0000);
    scan(32'h0, rd);
    chk("R3 blocked while rocc set", rd, 32'h8000_0000);
    scan(CTL_ALL, rd);
    chk("R4 rocc cleared by write 0", rd, 32'h0);

    tlr = 1'b1;
    @(negedge tck);
    tlr = 1'b0;
    idle(5);
    chk("R10 tlr clears cpu controls", cpu_ctl_bus(), 32'h0);
    scan(32'h0, rd);
    chk("R10 tlr readback", rd, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule